// File: doc/BRIEF.md
# Five-Source Prioritised Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit controller core. It has five sources: two active-low external pins, two timer overflow pulses, and one serial source, which is the OR of a receive-done flag and a transmit-done flag. For each source it keeps a pending flag. Software sets a per-source enable, a master enable, a per-source high/low priority and a per-pin edge/level mode through one register write port.

The external pins pass through a synchroniser. They are sampled only on cycles that carry the machine-cycle strobe. The block picks one winner and presents a registered request with a vector address. That vector is held until the core acknowledges. On acknowledge the winner's flag is cleared where the source's rules say so, and the winner's priority level is pushed onto a two-level in-service record. A return strobe pops that record. A high-priority source may interrupt a low-priority handler. Nothing interrupts a handler of its own level or of a higher level.

Top module: `mcu_irq_ctrl`

## Requirements
- R1: After reset, all six flags read 0, `irq_req` is 0 and `irq_vec` is 0x0000.
- R2: A source can request only while both the master enable (enable register bit 7) and its own enable bit (bits 4:0, ext0, tmr0, ext1, tmr1, serial) are 1.
- R3: Within one priority level the winner is the lowest-numbered source in the order ext0, tmr0, ext1, tmr1, serial. Its vector is 0x0003 + 8 × index, so the vectors are 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R4: A pending enabled source whose priority bit is 1 beats every low-priority source, whatever its position in that order.
- R5: With a pin in edge mode (mode register bit 0 for ext0, bit 1 for ext1, 1 = edge), its flag is set when one strobe sample of the pin is high and the next is low. Acknowledging that source clears the flag.
- R6: With a pin in level mode, its flag is loaded with the inverted pin on every strobe. Acknowledging that source does not clear the flag.
- R7: A one-cycle timer pulse sets that timer's flag. Acknowledging the timer clears the flag. When a pulse and the clear fall in the same cycle, the flag stays set.
- R8: The receive-done and transmit-done pulses set flags 4 and 5. Acknowledging the serial source leaves both flags unchanged.
- R9: No request is raised while a handler of the same or a higher level is in service. A high-priority request is raised during a low-priority handler. `irq_reti` ends the most recent handler.
- R10: While `irq_req` is 1 and no acknowledge arrives, `irq_vec` and `irq_req` hold, even if a better source becomes pending.
- R11: Register write port addresses: 0 is the flags (bit 0 ext0, bit 1 tmr0, bit 2 ext1, bit 3 tmr1, bit 4 receive, bit 5 transmit), 1 is enable, 2 is priority (bits 4:0, 1 = high), 3 is mode. A flag write replaces all six flags, and `flag_q` shows them in the same bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_tick | input | 1 | Machine-cycle strobe that samples the pins |
| ext_pin_n | input | 2 | Asynchronous active-low external interrupt pins |
| tmr_ovf | input | 2 | One-cycle overflow pulses from timer 0 and timer 1 |
| ser_rx_done | input | 1 | One-cycle receive-complete pulse |
| ser_tx_done | input | 1 | One-cycle transmit-complete pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Register write data |
| irq_ack | input | 1 | Core has taken the presented vector |
| irq_reti | input | 1 | Core has returned from a handler |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector address of the presented source |
| flag_q | output | 6 | Current pending flags |

## Verification
The hazard that matters is a hardware flag set landing in the same cycle as the clear that acknowledge triggers for that flag. The bench raises a timer overflow pulse on exactly the edge where the core acknowledges that timer. It then requires the timer flag to still read 1. A second overlap tested is a better source arriving while an earlier vector is still presented. The bench expects the old vector to stay until acknowledge. Constrained-random flag, enable and priority patterns are scored against a bench model of the polling order.

// File: rtl/mcu_irq_pkg.sv
package mcu_irq_pkg;
  localparam int NSRC  = 5;
  localparam int NFLAG = 6;
  localparam int NPIN  = 2;
  localparam int SRC_W = $clog2(NSRC);

  localparam int FL_EXT0 = 0;
  localparam int FL_TMR0 = 1;
  localparam int FL_EXT1 = 2;
  localparam int FL_TMR1 = 3;
  localparam int FL_RX   = 4;
  localparam int FL_TX   = 5;

  typedef enum logic [SRC_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4
  } src_e;

  localparam logic [1:0] WA_FLAGS  = 2'd0;
  localparam logic [1:0] WA_ENABLE = 2'd1;
  localparam logic [1:0] WA_PRIO   = 2'd2;
  localparam logic [1:0] WA_MODE   = 2'd3;

  localparam int MASTER_BIT = 7;
endpackage

// File: rtl/irq_pin_sampler.sv
module irq_pin_sampler #(
  parameter int N_PINS      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mc_tick,
  input  logic [N_PINS-1:0] pin_n,
  output logic [N_PINS-1:0] edge_hit,
  output logic [N_PINS-1:0] pin_low
);
  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] chain;
    logic                   smp_q;
    logic                   sync_v;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '1;
        smp_q <= 1'b1;
      end else begin
        chain <= {chain[SYNC_STAGES-2:0], pin_n[p]};
        if (mc_tick) smp_q <= sync_v;
      end
    end

    assign sync_v      = chain[SYNC_STAGES-1];
    assign edge_hit[p] = mc_tick & smp_q & ~sync_v;
    assign pin_low[p]  = ~sync_v;
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import mcu_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mc_tick,
  input  logic [NPIN-1:0]  edge_hit,
  input  logic [NPIN-1:0]  pin_low,
  input  logic [NPIN-1:0]  tmr_ovf,
  input  logic             ser_rx,
  input  logic             ser_tx,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             clr_en,
  input  logic [SRC_W-1:0] clr_src,
  output logic [NFLAG-1:0] flags,
  output logic [NSRC-1:0]  src_en,
  output logic             master_en,
  output logic [NSRC-1:0]  src_hi
);
  logic [NPIN-1:0]  mode_q;
  logic [NFLAG-1:0] nxt;
  logic             unused_wr;

  assign unused_wr = wr_data[6];

  always_comb begin
    nxt = flags;
    if (wr_en && wr_addr == WA_FLAGS) nxt = wr_data[NFLAG-1:0];
    // clear on vectoring, per source rule
    if (clr_en) begin
      case (clr_src)
        SRC_EXT0: if (mode_q[0]) nxt[FL_EXT0] = 1'b0;
        SRC_TMR0: nxt[FL_TMR0] = 1'b0;
        SRC_EXT1: if (mode_q[1]) nxt[FL_EXT1] = 1'b0;
        SRC_TMR1: nxt[FL_TMR1] = 1'b0;
        default:  ;
      endcase
    end
    // hardware events win over the clear
    for (int i = 0; i < NPIN; i++) begin
      if (mode_q[i]) begin
        if (edge_hit[i]) nxt[2*i] = 1'b1;
      end else if (mc_tick) begin
        nxt[2*i] = pin_low[i];
      end
      if (tmr_ovf[i]) nxt[2*i+1] = 1'b1;
    end
    if (ser_rx) nxt[FL_RX] = 1'b1;
    if (ser_tx) nxt[FL_TX] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags     <= '0;
      src_en    <= '0;
      master_en <= 1'b0;
      src_hi    <= '0;
      mode_q    <= '0;
    end else begin
      flags <= nxt;
      if (wr_en) begin
        case (wr_addr)
          WA_ENABLE: begin
            src_en    <= wr_data[NSRC-1:0];
            master_en <= wr_data[MASTER_BIT];
          end
          WA_PRIO: src_hi <= wr_data[NSRC-1:0];
          WA_MODE: mode_q <= wr_data[NPIN-1:0];
          default: ;
        endcase
      end
    end
  end

  AST_TMR_SET: assert property (@(posedge clk) disable iff (rst)
    tmr_ovf[0] |=> flags[FL_TMR0]); // R7

  AST_SER_KEEP: assert property (@(posedge clk) disable iff (rst)
    (clr_en && clr_src == SRC_SER && !(wr_en && wr_addr == WA_FLAGS))
    |=> ((flags[FL_TX:FL_RX] & $past(flags[FL_TX:FL_RX])) == $past(flags[FL_TX:FL_RX]))); // R8
endmodule

// File: rtl/irq_select.sv
module irq_select
  import mcu_irq_pkg::*;
#(
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] flags,
  input  logic [NSRC-1:0]  src_en,
  input  logic             master_en,
  input  logic [NSRC-1:0]  src_hi,
  input  logic             ack,
  input  logic             reti,
  output logic             req_q,
  output logic [VEC_W-1:0] vec_q,
  output logic             take,
  output logic [SRC_W-1:0] take_src
);
  logic [VEC_W-1:0] vec_lut [NSRC];
  logic [NSRC-1:0]  src_act, cand, c_hi, c_lo, pick;
  logic             found, lvl, lvl_q;
  logic [SRC_W-1:0] win, win_q;
  logic             ins_hi, ins_lo, hi_n, lo_n;

  for (genvar k = 0; k < NSRC; k++) begin : g_vec
    assign vec_lut[k] = VEC_W'(VEC_BASE + k * VEC_STRIDE);
  end

  assign src_act = {flags[FL_RX] | flags[FL_TX], flags[FL_TMR1:FL_EXT0]};
  assign cand    = src_act & src_en & {NSRC{master_en}};
  assign c_hi    = cand & src_hi;
  assign c_lo    = cand & ~src_hi;

  always_comb begin
    pick = '0;
    lvl  = 1'b0;
    if (!ins_hi && |c_hi) begin
      pick = c_hi;
      lvl  = 1'b1;
    end else if (!ins_hi && !ins_lo && |c_lo) begin
      pick = c_lo;
    end
    found = |pick;
    win   = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (pick[k]) win = SRC_W'(k);
    end
  end

  assign take     = ack & req_q;
  assign take_src = win_q;

  always_comb begin
    hi_n = ins_hi;
    lo_n = ins_lo;
    if (reti) begin
      if (ins_hi) hi_n = 1'b0;
      else        lo_n = 1'b0;
    end
    if (take) begin
      if (lvl_q) hi_n = 1'b1;
      else       lo_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      vec_q  <= '0;
      win_q  <= '0;
      lvl_q  <= 1'b0;
      ins_hi <= 1'b0;
      ins_lo <= 1'b0;
    end else begin
      ins_hi <= hi_n;
      ins_lo <= lo_n;
      if (take) begin
        req_q <= 1'b0;
      end else if (!req_q && found) begin
        req_q <= 1'b1;
        win_q <= win;
        lvl_q <= lvl;
        vec_q <= vec_lut[win];
      end
    end
  end

  AST_HOLD_VEC: assert property (@(posedge clk) disable iff (rst)
    (req_q && !ack) |=> (req_q && $stable(vec_q))); // R10

  AST_NO_SAME_LVL: assert property (@(posedge clk) disable iff (rst)
    req_q |-> !ins_hi); // R9

  AST_LO_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (req_q && ins_lo) |-> lvl_q); // R9
endmodule

// File: rtl/mcu_irq_ctrl.sv
module mcu_irq_ctrl
  import mcu_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W       = 16,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STRIDE  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mc_tick,
  input  logic [1:0]       ext_pin_n,
  input  logic [1:0]       tmr_ovf,
  input  logic             ser_rx_done,
  input  logic             ser_tx_done,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             irq_ack,
  input  logic             irq_reti,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic [5:0]       flag_q
);
  logic [NPIN-1:0]  edge_hit, pin_low;
  logic [NFLAG-1:0] flags;
  logic [NSRC-1:0]  src_en, src_hi;
  logic             master_en, take;
  logic [SRC_W-1:0] take_src;

  irq_pin_sampler #(.N_PINS(NPIN), .SYNC_STAGES(SYNC_STAGES)) u_pins (
    .clk(clk), .rst(rst), .mc_tick(mc_tick), .pin_n(ext_pin_n),
    .edge_hit(edge_hit), .pin_low(pin_low)
  );

  irq_flag_bank u_flags (
    .clk(clk), .rst(rst), .mc_tick(mc_tick), .edge_hit(edge_hit),
    .pin_low(pin_low), .tmr_ovf(tmr_ovf), .ser_rx(ser_rx_done),
    .ser_tx(ser_tx_done), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .clr_en(take), .clr_src(take_src),
    .flags(flags), .src_en(src_en), .master_en(master_en), .src_hi(src_hi)
  );

  irq_select #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) u_sel (
    .clk(clk), .rst(rst), .flags(flags), .src_en(src_en),
    .master_en(master_en), .src_hi(src_hi), .ack(irq_ack), .reti(irq_reti),
    .req_q(irq_req), .vec_q(irq_vec), .take(take), .take_src(take_src)
  );

  assign flag_q = flags;
endmodule

// File: tb/mcu_irq_ctrl_tb.sv
`timescale 1ns/1ps
module mcu_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mc_tick = 1'b0;
  logic [1:0]  ext_pin_n = 2'b11;
  logic [1:0]  tmr_ovf = 2'b00;
  logic        ser_rx_done = 1'b0, ser_tx_done = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic        irq_ack = 1'b0, irq_reti = 1'b0;
  logic        irq_req;
  logic [15:0] irq_vec;
  logic [5:0]  flag_q;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  mcu_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .mc_tick(mc_tick), .ext_pin_n(ext_pin_n),
    .tmr_ovf(tmr_ovf), .ser_rx_done(ser_rx_done), .ser_tx_done(ser_tx_done),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_ack(irq_ack), .irq_reti(irq_reti),
    .irq_req(irq_req), .irq_vec(irq_vec), .flag_q(flag_q)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic do_ack();
    irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
  endtask

  task automatic do_reti();
    irq_reti = 1'b1; cyc(1); irq_reti = 1'b0;
  endtask

  task automatic do_tick();
    mc_tick = 1'b1; cyc(1); mc_tick = 1'b0;
  endtask

  task automatic pulse_tmr(input int i);
    tmr_ovf[i] = 1'b1; cyc(1); tmr_ovf = 2'b00;
  endtask

  function automatic int exp_win(input logic [5:0] f, input logic [4:0] e,
                                 input logic m, input logic [4:0] p);
    logic [4:0] act, cand, sel;
    act  = {f[4] | f[5], f[3:0]};
    cand = act & e & {5{m}};
    sel  = (|(cand & p)) ? (cand & p) : (cand & ~p);
    for (int k = 0; k < 5; k++) if (sel[k]) return k;
    return 7;
  endfunction

  initial begin
    cyc(200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4021));
    cyc(3); rst = 1'b0; cyc(1);
    chk("R1 flags", flag_q, 0);
    chk("R1 req", irq_req, 0);
    chk("R1 vec", irq_vec, 0);

    // R11 register readback of flags
    wr(2'd0, 8'h2A); chk("R11 flag write", flag_q, 'h2A);
    wr(2'd0, 8'h00);

    // R2 enables
    wr(2'd0, 8'h02); wr(2'd1, 8'h02); cyc(1);
    chk("R2 no master", irq_req, 0);
    wr(2'd1, 8'h80); cyc(1);
    chk("R2 no source", irq_req, 0);
    wr(2'd1, 8'h82); cyc(1);
    chk("R2 both set", irq_req, 1);
    chk("R3 tmr0 vec", irq_vec, 'h000B);
    do_ack();
    chk("R7 tmr clear on ack", flag_q[1], 0);
    wr(2'd1, 8'h00); do_reti();

    // R3 ordering, R6 level ext not cleared
    wr(2'd0, 8'h3E); wr(2'd1, 8'h9F); cyc(1);
    chk("R3 order tmr0 first", irq_vec, 'h000B);
    do_ack(); cyc(2);
    chk("R9 same level blocked", irq_req, 0);
    do_reti(); cyc(1);
    chk("R3 next ext1", irq_vec, 'h0013);
    do_ack();
    chk("R6 level kept on ack", flag_q[2], 1);
    wr(2'd1, 8'h00); wr(2'd0, 8'h00); do_reti();

    // R4 high priority beats order
    wr(2'd0, 8'h09); wr(2'd2, 8'h08); wr(2'd1, 8'h89); cyc(1);
    chk("R4 hi tmr1 wins", irq_vec, 'h001B);
    do_ack(); cyc(2);
    chk("R9 low blocked by hi", irq_req, 0);
    do_reti(); cyc(1);
    chk("R9 low after pop", irq_vec, 'h0003);
    do_ack();
    wr(2'd1, 8'h00); wr(2'd0, 8'h00); do_reti(); wr(2'd2, 8'h00);

    // R9 preemption
    wr(2'd2, 8'h08); wr(2'd1, 8'h8A);
    pulse_tmr(0); cyc(1);
    chk("R9 low req", irq_vec, 'h000B);
    do_ack(); pulse_tmr(0); cyc(2);
    chk("R9 same level no req", irq_req, 0);
    pulse_tmr(1); cyc(1);
    chk("R9 preempt req", irq_req, 1);
    chk("R9 preempt vec", irq_vec, 'h001B);
    do_ack(); cyc(2);
    chk("R9 hi in service", irq_req, 0);
    do_reti(); cyc(2);
    chk("R9 lo still in service", irq_req, 0);
    do_reti(); cyc(1);
    chk("R9 resume low", irq_vec, 'h000B);
    do_ack(); wr(2'd1, 8'h00); wr(2'd0, 8'h00); do_reti(); wr(2'd2, 8'h00);

    // R10 hold
    wr(2'd1, 8'h8A); pulse_tmr(1); cyc(1);
    chk("R10 first vec", irq_vec, 'h001B);
    pulse_tmr(0); cyc(2);
    chk("R10 vec held", irq_vec, 'h001B);
    chk("R10 req held", irq_req, 1);
    do_ack(); do_reti(); cyc(1);
    chk("R10 later tmr0", irq_vec, 'h000B);
    do_ack(); wr(2'd1, 8'h00); wr(2'd0, 8'h00); do_reti();

    // R7 set and clear in the same cycle
    wr(2'd1, 8'h82); pulse_tmr(0); cyc(1);
    chk("R7 req", irq_vec, 'h000B);
    irq_ack = 1'b1; tmr_ovf[0] = 1'b1; cyc(1); irq_ack = 1'b0; tmr_ovf = 2'b00;
    chk("R7 set beats clear", flag_q[1], 1);
    wr(2'd1, 8'h00); wr(2'd0, 8'h00); do_reti();

    // R8 serial
    wr(2'd1, 8'h90);
    ser_rx_done = 1'b1; cyc(1); ser_rx_done = 1'b0; cyc(1);
    chk("R8 serial vec", irq_vec, 'h0023);
    do_ack();
    chk("R8 rx kept", flag_q[5:4], 1);
    ser_tx_done = 1'b1; cyc(1); ser_tx_done = 1'b0;
    chk("R8 tx set", flag_q[5:4], 3);
    wr(2'd1, 8'h00); wr(2'd0, 8'h00); do_reti();

    // R5 edge mode
    wr(2'd3, 8'h03); wr(2'd1, 8'h81);
    ext_pin_n[0] = 1'b0; cyc(3);
    chk("R5 no tick no flag", flag_q[0], 0);
    do_tick();
    chk("R5 edge flag", flag_q[0], 1);
    cyc(1);
    chk("R5 edge vec", irq_vec, 'h0003);
    do_ack();
    chk("R5 cleared on ack", flag_q[0], 0);
    do_tick();
    chk("R5 held low no edge", flag_q[0], 0);
    wr(2'd1, 8'h00); do_reti();
    ext_pin_n[0] = 1'b1; cyc(3); do_tick();

    // R6 level mirror
    wr(2'd3, 8'h00);
    ext_pin_n[1] = 1'b0; cyc(3); do_tick();
    chk("R6 level low", flag_q[2], 1);
    ext_pin_n[1] = 1'b1; cyc(3); do_tick();
    chk("R6 level high", flag_q[2], 0);

    // random patterns: R3 R4 R2 R11
    wr(2'd3, 8'h03);
    for (int it = 0; it < 300; it++) begin
      logic [5:0] f; logic [4:0] e, p; logic m; int w; logic [5:0] fx;
      f = 6'($urandom); e = 5'($urandom); p = 5'($urandom); m = 1'($urandom);
      wr(2'd0, {2'b00, f}); wr(2'd2, {3'b000, p}); wr(2'd1, {m, 2'b00, e});
      cyc(1);
      w = exp_win(f, e, m, p);
      chk("R2 R4 random req", irq_req, (w != 7) ? 1 : 0);
      if (w != 7) begin
        chk("R3 random vec", irq_vec, 3 + 8 * w);
        do_ack();
        fx = f;
        if (w < 4) fx[w] = 1'b0;
        chk("R5 R7 R8 random flags", flag_q, fx);
        wr(2'd1, 8'h00); wr(2'd0, 8'h00); do_reti();
      end else begin
        wr(2'd1, 8'h00); wr(2'd0, 8'h00);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule